// File: doc/BRIEF.md
# Bit-Pipelined Ripple-Carry Adder

This block adds a stream of unsigned operand pairs. It does not settle a whole carry chain in one cycle. Each bit position has its own full adder, and a register sits behind each one. The carry leaves bit i through a flop and reaches bit i+1 one cycle later. Operand bits for higher positions wait in the earlier stage registers so that they meet their incoming carry. Sum bits made in early stages ride forward through the later registers, so the full result word and the carry-out leave together.

The datapath opens with a capture stage and closes with an output stage. These stand in for the memory read and write that would surround the adder, so a parameter width of W gives W+2 register stages. Both edges use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high. The whole pipe advances as one unit whenever the output register is empty or the consumer is ready. When the consumer holds `out_ready` low while `out_valid` is high, every stage freezes and `in_ready` drops in that same cycle. A producer must then keep `in_valid`, `in_a` and `in_b` steady until the transfer happens. Once the pipe is full and the consumer keeps taking results, one sum leaves every cycle.

Top module: `skew_ripple_adder`

## Requirements
- R1: For every accepted pair, the output word {out_carry, out_sum} equals the exact (W+1)-bit unsigned sum in_a + in_b, with out_carry as the most significant bit.
- R2: With out_ready held high, a pair presented with in_valid in cycle t appears with out_valid in cycle t+W+2 (t+6 at the default W=4).
- R3: Pairs offered on consecutive cycles are accepted every cycle, and results leave one per cycle in acceptance order.
- R4: The carry into bit 0 is zero. 0+0 gives 0 with out_carry 0, 15+1 gives sum 0 with out_carry 1, and 15+15 gives sum 14 with out_carry 1.
- R5: A synchronous active-high rst empties every stage. out_valid is low during reset and after its release, until a new pair has travelled the full latency, and pairs in flight at reset never emerge.
- R6: While out_valid is high and out_ready is low, in_ready is low, and on the next cycle out_valid stays high with out_sum and out_carry unchanged.
- R7: Outside reset, in_ready is high whenever out_valid is low or out_ready is high.
- R8: Cycles without an accepted pair produce no result, so the number of results equals the number of accepted pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The pipe can take a pair this cycle |
| in_a | input | W | First operand, unsigned |
| in_b | input | W | Second operand, unsigned |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_sum | output | W | Low W bits of the sum |
| out_carry | output | 1 | Carry out of the top bit |

## Verification
Suppose one stage latches a wrong carry or a skewed operand bit. The damage shows only in bits at that position or above, and only in the result that leaves the output register the number of stages remaining after the fault. Corner operands such as all-ones plus one expose a broken carry hop within one latency period. A stage that loses its valid bit, or fails to hold during a stall, shows at once as a missing, duplicated or shifted result against the ordered stream of expected sums. A bad stall also shows as a sum that changes while out_ready is low.

// File: rtl/skew_ripple_adder_pkg.sv
package skew_ripple_adder_pkg;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_result_t;

  function automatic fa_result_t full_add(input logic x, input logic y, input logic cin);
    fa_result_t r;
    r.sum   = x ^ y ^ cin;
    r.carry = (x & y) | (x & cin) | (y & cin);
    return r;
  endfunction

endpackage

// File: rtl/sra_capture_stage.sv
module sra_capture_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         v_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      a_o <= '0;
      b_o <= '0;
    end else if (adv) begin
      v_o <= v_i;
      a_o <= a_i;
      b_o <= b_i;
    end
  end
endmodule

// File: rtl/sra_bit_stage.sv
module sra_bit_stage
  import skew_ripple_adder_pkg::*;
#(
  parameter int W   = 4,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] s_i,
  input  logic         c_i,
  output logic         v_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  // operand bits still needed by later stages: positions above IDX
  localparam logic [W-1:0] KEEP = ({W{1'b1}} << (IDX + 1));

  fa_result_t   fa;
  logic [W-1:0] s_next;
  logic         unused_consumed;

  assign unused_consumed = ^{a_i & ~KEEP, b_i & ~KEEP};

  always_comb begin
    fa          = full_add(a_i[IDX], b_i[IDX], c_i);
    s_next      = s_i;
    s_next[IDX] = fa.sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      a_o <= '0;
      b_o <= '0;
      s_o <= '0;
      c_o <= 1'b0;
    end else if (adv) begin
      v_o <= v_i;
      a_o <= a_i & KEEP;
      b_o <= b_i & KEEP;
      s_o <= s_next;
      c_o <= fa.carry;
    end
  end
endmodule

// File: rtl/sra_output_stage.sv
module sra_output_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         v_i,
  input  logic [W-1:0] s_i,
  input  logic         c_i,
  output logic         v_o,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      s_o <= '0;
      c_o <= 1'b0;
    end else if (adv) begin
      v_o <= v_i;
      s_o <= s_i;
      c_o <= c_i;
    end
  end
endmodule

// File: rtl/skew_ripple_adder.sv
module skew_ripple_adder #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sum,
  output logic         out_carry
);
  // chain index k carries the signals entering adder stage k; index W leaves the last one
  logic         v_ch [W+1];
  logic [W-1:0] a_ch [W+1];
  logic [W-1:0] b_ch [W+1];
  logic [W-1:0] s_ch [W+1];
  logic         c_ch [W+1];
  logic         adv;
  logic         unused_tail;

  // single advance for the whole pipe: move when the output slot frees up
  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  sra_capture_stage #(.W(W)) u_capture (
    .clk (clk), .rst (rst), .adv (adv),
    .v_i (in_valid), .a_i (in_a), .b_i (in_b),
    .v_o (v_ch[0]), .a_o (a_ch[0]), .b_o (b_ch[0])
  );

  assign s_ch[0] = '0;
  assign c_ch[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    sra_bit_stage #(.W(W), .IDX(k)) u_bit (
      .clk (clk), .rst (rst), .adv (adv),
      .v_i (v_ch[k]),   .a_i (a_ch[k]),   .b_i (b_ch[k]),
      .s_i (s_ch[k]),   .c_i (c_ch[k]),
      .v_o (v_ch[k+1]), .a_o (a_ch[k+1]), .b_o (b_ch[k+1]),
      .s_o (s_ch[k+1]), .c_o (c_ch[k+1])
    );
  end

  assign unused_tail = ^{a_ch[W], b_ch[W]};

  sra_output_stage #(.W(W)) u_output (
    .clk (clk), .rst (rst), .adv (adv),
    .v_i (v_ch[W]), .s_i (s_ch[W]), .c_i (c_ch[W]),
    .v_o (out_valid), .s_o (out_sum), .c_o (out_carry)
  );
endmodule

// File: rtl/skew_ripple_adder_chk.sv
module skew_ripple_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sum,
  input logic         out_carry
);
  localparam int LAT = W + 2;

  logic         ref_v [LAT];
  logic [W:0]   ref_s [LAT];
  logic         ref_adv;

  assign ref_adv = ~ref_v[LAT-1] | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        ref_v[i] <= 1'b0;
        ref_s[i] <= '0;
      end
    end else if (ref_adv) begin
      ref_v[0] <= in_valid;
      ref_s[0] <= {1'b0, in_a} + {1'b0, in_b};
      for (int i = 1; i < LAT; i++) begin
        ref_v[i] <= ref_v[i-1];
        ref_s[i] <= ref_s[i-1];
      end
    end
  end

  AST_SUM_EXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({out_carry, out_sum} == ref_s[LAT-1])); // R1

  AST_LATENCY_TRACK: assert property (@(posedge clk) disable iff (rst)
    out_valid == ref_v[LAT-1]); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry))); // R6

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!ref_v[LAT-1]) |-> !out_valid); // R8
endmodule

bind skew_ripple_adder skew_ripple_adder_chk #(.W(W)) u_chk (
  .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
  .in_a (in_a), .in_b (in_b), .out_valid (out_valid), .out_ready (out_ready),
  .out_sum (out_sum), .out_carry (out_carry)
);

// File: tb/skew_ripple_adder_test.sv
module skew_ripple_adder_test;
  localparam int W   = 4;
  localparam int LAT = W + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic         out_carry;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    lat_chk  = 1'b1;
  bit    rdy_rand = 1'b0;
  bit    finished = 1'b0;
  string cur_tag  = "R1";

  logic [W:0] exp_q [$];
  int         cyc_q [$];
  string      tag_q [$];

  bit         prev_stall = 1'b0;
  logic [W:0] prev_out   = '0;

  skew_ripple_adder #(.W(W)) uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_a (in_a), .in_b (in_b), .out_valid (out_valid), .out_ready (out_ready),
    .out_sum (out_sum), .out_carry (out_carry)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: everything is stable at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete(); cyc_q.delete(); tag_q.delete();
      prev_stall = 1'b0;
    end else begin
      chk(in_ready == (!out_valid || out_ready), "R7", int'(in_ready), int'(!out_valid || out_ready));
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
        chk({out_carry, out_sum} == prev_out, "R6 data", int'({out_carry, out_sum}), int'(prev_out));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 extra result", int'({out_carry, out_sum}), 0);
        end else begin
          logic [W:0] e;
          int         c0;
          string      t;
          e  = exp_q.pop_front();
          c0 = cyc_q.pop_front();
          t  = tag_q.pop_front();
          chk({out_carry, out_sum} == e, {t, " sum"}, int'({out_carry, out_sum}), int'(e));
          if (lat_chk) chk(cyc - c0 == LAT, "R2 latency", cyc - c0, LAT);
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(exp_sum(in_a, in_b));
        cyc_q.push_back(cyc);
        tag_q.push_back(cur_tag);
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_carry, out_sum};
    end
  end

  // consumer ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = 1'b1; in_a = a; in_b = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 reset valid", int'(out_valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R4 directed corners, back to back
    cur_tag = "R4";
    push(4'h0, 4'h0);
    push(4'hF, 4'h1);
    push(4'hF, 4'hF);
    push(4'h5, 4'hA);
    push(4'h8, 4'h8);
    push(4'h7, 4'h9);
    idle(LAT + 4);

    // R3 back-to-back random stream
    cur_tag = "R3";
    for (int i = 0; i < 60; i++) push(W'($urandom), W'($urandom));
    idle(LAT + 4);

    // R1 random with gaps (R8 bubbles)
    cur_tag = "R1";
    for (int i = 0; i < 150; i++) begin
      push(W'($urandom), W'($urandom));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(LAT + 4);

    // R6 back-pressure from the consumer
    cur_tag  = "R6";
    lat_chk  = 1'b0;
    rdy_rand = 1'b1;
    for (int i = 0; i < 200; i++) begin
      push(W'($urandom), W'($urandom));
      if (($urandom % 5) == 0) idle(1);
    end
    rdy_rand = 1'b0;
    idle(3 * LAT);
    chk(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);

    // R5 reset with pairs in flight
    cur_tag = "R5";
    push(4'h3, 4'h4);
    push(4'hE, 4'h2);
    push(4'h9, 4'h9);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 flushed", int'(out_valid), 0);
    end
    @(posedge clk); #1;
    push(4'hC, 4'h5);
    idle(LAT + 3);
    chk(exp_q.size() == 0, "R8 final", exp_q.size(), 0);

    finish_run();
  end
endmodule